// File: doc/BRIEF.md
# Sticky Stack-Bound Checker with Trail Scoreboard

This block watches the two growing stacks of a logic-language processor, the trail and the current environment, and warns early when either comes close to its programmed limit. Every pointer write is compared against that channel's limit and a programmable safety margin in words. A write that lands inside the margin, or at or beyond the limit, raises a sticky warning flag. The flag stays raised until software clears it, so the program can start garbage collection at a point it chooses and does not need a collision test on every call.

The block also keeps one trail-check bit for each general register. A register write that comes from a load, or from the last step of a dereference, and returns an unbound variable older than the newest choice point sets that register's bit, so a later binding through the register is known to need trailing. Any other write to a register clears its bit. Two read ports bring out the bits of the instruction's two source registers. For the two operand addresses, the block also produces combinational trail and environment condition signals that conditional instructions can test.

Top module: `bound_guard`

## Requirements
- R1: After synchronous reset, both sticky flags, every scoreboard bit and the held environment pointer are 0.
- R2: A pointer write on a channel sets that channel's sticky flag on the next clock edge when the written value is at or above the channel limit, or when limit minus value is less than or equal to the margin. Bit 0 of `sticky` and `flag_clr` is the trail channel and bit 1 is the environment channel.
- R3: A pointer write whose gap to the limit is greater than the margin does not set the flag. A flag that is set stays set while its clear bit is 0.
- R4: Writing 1 to a channel's clear bit clears its flag on the next edge, unless that cycle also has a write on the same channel that meets the R2 condition. In that case the flag stays set.
- R5: The trail and environment channels are independent. A write or clear on one does not change the other's flag.
- R6: `trail_a` (`trail_b`) is 1 exactly when `opa_addr` (`opb_addr`) is less than `cp_bound`, unsigned, in the same cycle.
- R7: `env_a` (`env_b`) is 1 exactly when the operand address is greater than or equal to the held environment pointer, which is the value of the last `env_we` write.
- R8: A register write with `rf_unbound`=1 and `rf_var_addr` < `cp_bound` sets scoreboard bit `rf_waddr` on the next edge.
- R9: Any other register write clears bit `rf_waddr`. Bits of registers not written keep their values.
- R10: `tchk_a` and `tchk_b` show the scoreboard bits selected by `rd_a_idx` and `rd_b_idx`, and reflect a write from the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trail_we | input | 1 | Trail pointer write strobe |
| trail_wdata | input | 32 | New trail pointer |
| trail_limit | input | 32 | Trail limit |
| trail_margin | input | 32 | Trail near-collision margin in words |
| env_we | input | 1 | Environment pointer write strobe |
| env_wdata | input | 32 | New environment pointer |
| env_limit | input | 32 | Environment limit |
| env_margin | input | 32 | Environment near-collision margin in words |
| flag_clr | input | 2 | Write-one-to-clear for the sticky flags |
| sticky | output | 2 | Sticky near-collision flags |
| cp_bound | input | 32 | Address of the newest choice-point boundary |
| opa_addr | input | 32 | Operand A variable address |
| opb_addr | input | 32 | Operand B variable address |
| trail_a | output | 1 | Operand A needs trailing |
| trail_b | output | 1 | Operand B needs trailing |
| env_a | output | 1 | Operand A lies in the current environment |
| env_b | output | 1 | Operand B lies in the current environment |
| rf_we | input | 1 | Register write strobe |
| rf_waddr | input | 5 | Register written |
| rf_unbound | input | 1 | Write is a load or final dereference that returned an unbound variable |
| rf_var_addr | input | 32 | Address of that variable |
| rd_a_idx | input | 5 | Source register A |
| rd_b_idx | input | 5 | Source register B |
| tchk_a | output | 1 | Trail-check bit of source register A |
| tchk_b | output | 1 | Trail-check bit of source register B |
| tchk_vec | output | 32 | All trail-check bits |

## Verification
The assertions assume that the limits and margins hold steady while they are being compared, and that `rf_waddr` always names a real register. Under the default parameters every 5-bit index does. The stimulus changes the limits only between directed phases. It draws pointer values from a window around each limit, so that writes fall inside the margin, exactly at it, and beyond the limit. The random clear pulses often land in the same cycle as a qualifying write, which exercises the rule that a new crossing wins over a clear.

// File: rtl/bg_pkg.sv
package bg_pkg;

    localparam int unsigned DEF_AW   = 32;
    localparam int unsigned DEF_NREG = 32;

    typedef enum logic [0:0] {
        CH_TRAIL = 1'b0,
        CH_ENV   = 1'b1
    } chan_e;

    localparam int unsigned NCH = 2;

    typedef enum logic [1:0] {
        SB_KEEP  = 2'd0,
        SB_CLEAR = 2'd1,
        SB_MARK  = 2'd2
    } sb_op_e;

    function automatic sb_op_e sb_decide(input logic we, input logic marks);
        if (!we)   return SB_KEEP;
        if (marks) return SB_MARK;
        return SB_CLEAR;
    endfunction

endpackage

// File: rtl/bg_zone.sv
module bg_zone #(
    parameter int unsigned AW = bg_pkg::DEF_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] margin,
    input  logic          clr,
    output logic [AW-1:0] ptr_q,
    output logic          flag_q
);
    logic [AW-1:0] gap;
    logic          past_limit;
    logic          near;

    always_comb begin
        gap        = limit - wdata;
        past_limit = (wdata >= limit);
        near       = past_limit || (gap <= margin);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (we) ptr_q <= wdata;
            flag_q <= (we && near) || (flag_q && !clr);
        end
    end

    // R2: a write past the limit always raises the flag
    p_set_past_limit_r2: assert property (@(posedge clk) disable iff (rst)
        (we && (wdata >= limit)) |=> flag_q);
    // R3: flag holds while no clear arrives
    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);
    // R4: a clear with no write drops the flag
    p_clear_drops_r4: assert property (@(posedge clk) disable iff (rst)
        (clr && !we) |=> !flag_q);
    // R7: held pointer follows writes
    p_ptr_track_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> (ptr_q == $past(wdata)));
endmodule

// File: rtl/bg_operand_cond.sv
module bg_operand_cond #(
    parameter int unsigned AW = bg_pkg::DEF_AW
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] cp_bound,
    input  logic [AW-1:0] env_ptr,
    output logic          trail_c,
    output logic          env_c
);
    always_comb begin
        trail_c = (addr < cp_bound);
        env_c   = (addr >= env_ptr);
    end
endmodule

// File: rtl/bg_trail_sb.sv
module bg_trail_sb #(
    parameter int unsigned AW   = bg_pkg::DEF_AW,
    parameter int unsigned NREG = bg_pkg::DEF_NREG,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IW-1:0]   waddr,
    input  logic            unbound,
    input  logic [AW-1:0]   var_addr,
    input  logic [AW-1:0]   cp_bound,
    input  logic [IW-1:0]   ra,
    input  logic [IW-1:0]   rb,
    output logic            fa,
    output logic            fb,
    output logic [NREG-1:0] vec
);
    import bg_pkg::*;

    logic   older;
    sb_op_e op;

    always_comb begin
        older = unbound && (var_addr < cp_bound);
        op    = sb_decide(we, older);
    end

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        logic hit;
        assign hit = (waddr == IW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                vec[i] <= 1'b0;
            end else if (hit) begin
                case (op)
                    SB_MARK:  vec[i] <= 1'b1;
                    SB_CLEAR: vec[i] <= 1'b0;
                    default:  vec[i] <= vec[i];
                endcase
            end
        end
    end

    assign fa = vec[ra];
    assign fb = vec[rb];

    // R9: untouched scoreboard when no register write
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(vec));
    // R9: a non-qualifying write clears the written entry
    p_write_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (we && !unbound) |=> !vec[$past(waddr)]);
    // R8: a qualifying write marks the entry
    p_mark_r8: assert property (@(posedge clk) disable iff (rst)
        (we && unbound && (var_addr < cp_bound)) |=> vec[$past(waddr)]);
    // R9: at most one entry changes per cycle
    p_one_change_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(vec ^ $past(vec)) <= 1));
endmodule

// File: rtl/bound_guard.sv
module bound_guard #(
    parameter int unsigned AW   = bg_pkg::DEF_AW,
    parameter int unsigned NREG = bg_pkg::DEF_NREG,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trail_we,
    input  logic [AW-1:0]   trail_wdata,
    input  logic [AW-1:0]   trail_limit,
    input  logic [AW-1:0]   trail_margin,
    input  logic            env_we,
    input  logic [AW-1:0]   env_wdata,
    input  logic [AW-1:0]   env_limit,
    input  logic [AW-1:0]   env_margin,
    input  logic [1:0]      flag_clr,
    output logic [1:0]      sticky,
    input  logic [AW-1:0]   cp_bound,
    input  logic [AW-1:0]   opa_addr,
    input  logic [AW-1:0]   opb_addr,
    output logic            trail_a,
    output logic            trail_b,
    output logic            env_a,
    output logic            env_b,
    input  logic            rf_we,
    input  logic [IW-1:0]   rf_waddr,
    input  logic            rf_unbound,
    input  logic [AW-1:0]   rf_var_addr,
    input  logic [IW-1:0]   rd_a_idx,
    input  logic [IW-1:0]   rd_b_idx,
    output logic            tchk_a,
    output logic            tchk_b,
    output logic [NREG-1:0] tchk_vec
);
    import bg_pkg::*;

    logic [NCH-1:0]         ch_we;
    logic [NCH-1:0][AW-1:0] ch_wdata;
    logic [NCH-1:0][AW-1:0] ch_limit;
    logic [NCH-1:0][AW-1:0] ch_margin;
    logic [NCH-1:0][AW-1:0] ch_ptr;
    logic [NCH-1:0]         ch_flag;

    always_comb begin
        ch_we[CH_TRAIL]     = trail_we;
        ch_wdata[CH_TRAIL]  = trail_wdata;
        ch_limit[CH_TRAIL]  = trail_limit;
        ch_margin[CH_TRAIL] = trail_margin;
        ch_we[CH_ENV]       = env_we;
        ch_wdata[CH_ENV]    = env_wdata;
        ch_limit[CH_ENV]    = env_limit;
        ch_margin[CH_ENV]   = env_margin;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        bg_zone #(.AW(AW)) u_zone (
            .clk    (clk),
            .rst    (rst),
            .we     (ch_we[c]),
            .wdata  (ch_wdata[c]),
            .limit  (ch_limit[c]),
            .margin (ch_margin[c]),
            .clr    (flag_clr[c]),
            .ptr_q  (ch_ptr[c]),
            .flag_q (ch_flag[c])
        );
    end

    assign sticky = ch_flag;

    logic [1:0][AW-1:0] op_addr;
    logic [1:0]         op_trail;
    logic [1:0]         op_env;

    assign op_addr[0] = opa_addr;
    assign op_addr[1] = opb_addr;

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        bg_operand_cond #(.AW(AW)) u_cond (
            .addr     (op_addr[k]),
            .cp_bound (cp_bound),
            .env_ptr  (ch_ptr[CH_ENV]),
            .trail_c  (op_trail[k]),
            .env_c    (op_env[k])
        );
    end

    assign trail_a = op_trail[0];
    assign trail_b = op_trail[1];
    assign env_a   = op_env[0];
    assign env_b   = op_env[1];

    bg_trail_sb #(.AW(AW), .NREG(NREG)) u_sb (
        .clk      (clk),
        .rst      (rst),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .unbound  (rf_unbound),
        .var_addr (rf_var_addr),
        .cp_bound (cp_bound),
        .ra       (rd_a_idx),
        .rb       (rd_b_idx),
        .fa       (tchk_a),
        .fb       (tchk_b),
        .vec      (tchk_vec)
    );

    // R5: a channel with no write and no clear keeps its flag
    p_chan_indep_r5: assert property (@(posedge clk) disable iff (rst)
        (!trail_we && !flag_clr[0]) |=> (sticky[0] == $past(sticky[0])));
    // R1: reset leaves everything clear
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (sticky == 2'b00 && tchk_vec == '0));
endmodule

// File: tb/bound_guard_bench.sv
module bound_guard_bench;
    localparam int AW = 32;
    localparam int NR = 32;

    logic clk = 1'b0;
    logic rst;
    logic trail_we, env_we, rf_we, rf_unbound;
    logic [AW-1:0] trail_wdata, trail_limit, trail_margin;
    logic [AW-1:0] env_wdata, env_limit, env_margin;
    logic [1:0] flag_clr, sticky;
    logic [AW-1:0] cp_bound, opa_addr, opb_addr, rf_var_addr;
    logic trail_a, trail_b, env_a, env_b, tchk_a, tchk_b;
    logic [4:0] rf_waddr, rd_a_idx, rd_b_idx;
    logic [NR-1:0] tchk_vec;

    always #2 clk = ~clk;

    bound_guard u_bound_guard (.*);

    int vectors = 0;
    int fails = 0;
    logic [1:0] m_sticky;
    logic [AW-1:0] m_envp;
    logic [NR-1:0] m_sb;

    function automatic logic near(input logic [AW-1:0] p, lim, mar);
        return (p >= lim) || ((lim - p) <= mar);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        trail_we = 0; env_we = 0; rf_we = 0; rf_unbound = 0;
        flag_clr = 0;
    endtask

    // inputs already driven after a negedge: check comb, step model, clock, check regs
    task automatic cycle();
        logic [1:0] nxt;
        #1;
        chk("R6 trail_a", trail_a, opa_addr < cp_bound);
        chk("R6 trail_b", trail_b, opb_addr < cp_bound);
        chk("R7 env_a", env_a, opa_addr >= m_envp);
        chk("R7 env_b", env_b, opb_addr >= m_envp);
        chk("R10 tchk_a", tchk_a, m_sb[rd_a_idx]);
        chk("R10 tchk_b", tchk_b, m_sb[rd_b_idx]);
        nxt[0] = (trail_we && near(trail_wdata, trail_limit, trail_margin)) || (m_sticky[0] && !flag_clr[0]);
        nxt[1] = (env_we && near(env_wdata, env_limit, env_margin)) || (m_sticky[1] && !flag_clr[1]);
        m_sticky = nxt;
        if (env_we) m_envp = env_wdata;
        if (rf_we) m_sb[rf_waddr] = rf_unbound && (rf_var_addr < cp_bound);
        @(posedge clk); #1;
        chk("R2 R3 R4 R5 sticky", sticky, m_sticky);
        chk("R8 R9 scoreboard", tchk_vec, m_sb);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        idle();
        trail_wdata = 0; env_wdata = 0; rf_waddr = 0; rf_var_addr = 0;
        trail_limit = 1000; trail_margin = 16; env_limit = 2000; env_margin = 8;
        cp_bound = 500; opa_addr = 0; opb_addr = 0; rd_a_idx = 0; rd_b_idx = 1;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R1 sticky reset", sticky, 2'b00);
        chk("R1 scoreboard reset", tchk_vec, '0);
        chk("R1 env ptr reset", env_a, 1'b1);
        m_sticky = 0; m_envp = 0; m_sb = 0;

        // R3: gap one above margin does not set
        @(negedge clk); trail_we = 1; trail_wdata = 1000 - 17; cycle(); idle();
        // R2: gap exactly margin sets trail, env untouched (R5)
        trail_we = 1; trail_wdata = 1000 - 16; cycle(); idle();
        cycle();
        // R4: clear together with new crossing keeps it set
        flag_clr = 2'b01; trail_we = 1; trail_wdata = 1200; cycle(); idle();
        // R4: clear alone drops it
        flag_clr = 2'b01; cycle(); idle();
        // R2: env past limit, R5 trail stays clear
        env_we = 1; env_wdata = 2500; cycle(); idle();
        flag_clr = 2'b10; cycle(); idle();
        // R8/R9 directed
        rf_we = 1; rf_waddr = 5; rf_unbound = 1; rf_var_addr = 499; rd_a_idx = 5; cycle(); idle();
        rf_we = 1; rf_waddr = 6; rf_unbound = 1; rf_var_addr = 500; rd_b_idx = 6; cycle(); idle();
        rf_we = 1; rf_waddr = 5; rf_unbound = 0; rf_var_addr = 10; cycle(); idle();

        for (int i = 0; i < 3000; i++) begin
            trail_we = ($urandom % 3) == 0;
            trail_wdata = 900 + ($urandom % 200);
            env_we = ($urandom % 4) == 0;
            env_wdata = 1950 + ($urandom % 100);
            flag_clr = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
            cp_bound = 400 + ($urandom % 200);
            opa_addr = 1900 + ($urandom % 200);
            opb_addr = 350 + ($urandom % 300);
            rf_we = $urandom % 2;
            rf_waddr = 5'($urandom);
            rf_unbound = $urandom % 2;
            rf_var_addr = 350 + ($urandom % 300);
            rd_a_idx = 5'($urandom);
            rd_b_idx = 5'($urandom);
            cycle();
        end
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule